// File: doc/BRIEF.md
# Windowed Interrupt Routing Register File

This block holds the routing table of an interrupt controller and makes it reachable through two 32-bit bus locations: an index register and a data window. Software first writes the number of the wanted register into the index register, then reads or writes the data window to reach that register. Behind the window sit an identification register, a fixed version word, an arbitration word that mirrors the identification value, and one 64-bit routing entry per interrupt pin. Each entry is reached as a low and a high 32-bit half.

The full contents of every entry are driven out in parallel to an interrupt-delivery block. That neighbour sets and clears the remote-IRR bit of each entry through side-band strobes. Whenever software writes an entry, the block reports two things with one-cycle pulses and names the pin concerned. The first is that a routing field changed. The second is that the pin is level-triggered and currently asserted, so it has to be delivered again.

Top module: `irq_route_regs`

## Requirements
- R1: After reset every entry holds 0x0001000000010000 (mask bit 16 set in the low half and bit 48 set in the high half), the index register and the identification register hold zero, read data is zero and no event pulse is raised.
- R2: An access is accepted only when acc_size equals 4 (a 32-bit access, since acc_size counts bytes) and acc_addr is 0x00 (index) or 0x10 (window). Any other write changes nothing, and any other read returns zero.
- R3: The index register reads back all 32 written bits at offset 0x00. Only its low 8 bits choose the register behind the window.
- R4: Through the window, index 0x00 returns the identification register, index 0x02 returns the same value as the arbitration word, and index 0x01 returns ((NPIN-1) << 16) | 0x11, which is 0x001F0011 for 32 pins.
- R5: A window write at index 0x00 stores the data ANDed with 0x0F000000 (bits 27:24). Window writes at index 0x01 and 0x02 have no effect.
- R6: Entry n is reached at index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32. Every index that names no register reads as zero and ignores writes.
- R7: Bus writes never change bit 14 (remote-IRR) or bit 12 (delivery status) of an entry. irr_set[n] sets bit 14 of entry n and irr_clr[n] clears it.
- R8: When a window write leaves an entry with bit 15 (trigger mode, 1 = level) at 0, bit 14 of that entry is cleared in the same clock edge.
- R9: The cycle after a window write to entry n, route_chg is 1 and evt_pin is n when any bit other than bit 16 (mask) and bit 13 (polarity) differs from its value before the write. Otherwise route_chg is 0.
- R10: The cycle after a window write to entry n, redeliver is 1 and evt_pin is n when the written entry has bit 15 set and pin_level[n] is 1. Otherwise redeliver is 0.
- R11: Read data is registered: it appears in the cycle after the read strobe and holds its value until the next read. A write takes effect on the clock edge where it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| pin_level | input | NPIN | Current asserted state of each interrupt pin |
| irr_set | input | NPIN | Delivery block sets remote-IRR of an entry |
| irr_clr | input | NPIN | Delivery block clears remote-IRR of an entry |
| entry_tbl | output | NPIN*64 | All entries, entry n at bits 64n+63:64n |
| route_chg | output | 1 | Pulse: routing field of the written entry changed |
| redeliver | output | 1 | Pulse: written entry is level-triggered and its pin is asserted |
| evt_pin | output | PIN_W | Pin named by the current pulse, zero when no pulse is raised |

## Verification
Several checks run on every cycle. A route pulse may only follow an accepted window write. A redeliver pulse must name a pin that was asserted and an entry that is in level mode. Remote-IRR may rise only on a delivery strobe. An entry falling to edge mode must come out with remote-IRR clear. Bad-size reads must return zero, and read data must not move without a read. Other behaviours are shown only by the bench's scenarios, which compare every entry and every output with a behavioural model after each bus cycle. These cover the window decoding of each index, the identification mask, the protection of the read-only bits against all-ones writes, the exclusion of mask-only and polarity-only changes from route pulses, and the first and last entries.

// File: rtl/irr_pkg.sv
package irr_pkg;
   localparam int unsigned ENT_W   = 64;
   localparam int unsigned HALF_W  = 32;
   localparam int unsigned BIT_DLV  = 12;
   localparam int unsigned BIT_POL  = 13;
   localparam int unsigned BIT_IRR  = 14;
   localparam int unsigned BIT_TRIG = 15;
   localparam int unsigned BIT_MASK = 16;
   localparam logic [ENT_W-1:0] ENT_RST   = 64'h0001_0000_0001_0000;
   localparam logic [ENT_W-1:0] BUS_RO    = (64'd1 << BIT_IRR) | (64'd1 << BIT_DLV);
   localparam logic [ENT_W-1:0] ROUTE_IGN = (64'd1 << BIT_MASK) | (64'd1 << BIT_POL);
   localparam logic [HALF_W-1:0] ID_FIELD = 32'h0F00_0000;
   localparam logic [7:0] IX_ID   = 8'h00;
   localparam logic [7:0] IX_VER  = 8'h01;
   localparam logic [7:0] IX_ARB  = 8'h02;
   localparam logic [7:0] IX_ENT0 = 8'h10;
   localparam logic [HALF_W-1:0] VER_LOW = 32'h0000_0011;
   localparam int unsigned OFS_INDEX  = 0;
   localparam int unsigned OFS_WINDOW = 16;
   localparam logic [2:0] SIZE_WORD = 3'd4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ID,
      SEL_VER,
      SEL_ARB,
      SEL_ENT_LO,
      SEL_ENT_HI
   } win_sel_e;

   typedef struct packed {
      logic idx_wr;
      logic idx_rd;
      logic win_wr;
      logic win_rd;
      logic bad_rd;
   } acc_kind_t;
endpackage

// File: rtl/win_decode.sv
module win_decode
   import irr_pkg::*;
#(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned PIN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [2:0]        acc_size,
   input  logic [31:0]       acc_wdata,
   output acc_kind_t         kind,
   output logic [31:0]       idx_q,
   output win_sel_e          sel,
   output logic [PIN_W-1:0]  ent_num
);
   localparam int unsigned IX_END = int'(IX_ENT0) + 2 * NPIN;

   logic       size_ok;
   logic       at_idx;
   logic       at_win;
   logic [7:0] ix;
   logic [7:0] ix_off;

   assign size_ok = (acc_size == SIZE_WORD);
   assign at_idx  = (acc_addr == ADDR_W'(OFS_INDEX));
   assign at_win  = (acc_addr == ADDR_W'(OFS_WINDOW));

   always_comb begin
      kind.idx_wr = acc_valid &  acc_write & size_ok & at_idx;
      kind.idx_rd = acc_valid & ~acc_write & size_ok & at_idx;
      kind.win_wr = acc_valid &  acc_write & size_ok & at_win;
      kind.win_rd = acc_valid & ~acc_write & size_ok & at_win;
      kind.bad_rd = acc_valid & ~acc_write & ~(size_ok & (at_idx | at_win));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (kind.idx_wr) begin
         idx_q <= acc_wdata;
      end
   end

   assign ix     = idx_q[7:0];
   assign ix_off = ix - IX_ENT0;

   always_comb begin
      sel     = SEL_NONE;
      ent_num = ix_off[PIN_W:1];
      if (ix == IX_ID) begin
         sel = SEL_ID;
      end else if (ix == IX_VER) begin
         sel = SEL_VER;
      end else if (ix == IX_ARB) begin
         sel = SEL_ARB;
      end else if ((ix >= IX_ENT0) && (int'(ix) < int'(IX_END))) begin
         sel = ix_off[0] ? SEL_ENT_HI : SEL_ENT_LO;
      end
   end
endmodule

// File: rtl/route_entry.sv
module route_entry
   import irr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_hi,
   input  logic [31:0]      wdata,
   input  logic             irr_set,
   input  logic             irr_clr,
   input  logic             pin_lvl,
   output logic [ENT_W-1:0] entry_q,
   output logic             route_chg,
   output logic             redo
);
   logic [ENT_W-1:0] base;
   logic [ENT_W-1:0] nxt;
   logic [ENT_W-1:0] half_mask;
   logic [ENT_W-1:0] data64;
   logic [ENT_W-1:0] wr_mask;

   always_comb begin
      base = entry_q;
      if (irr_set) base[BIT_IRR] = 1'b1;
      if (irr_clr) base[BIT_IRR] = 1'b0;

      half_mask = wr_hi ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
      data64    = wr_hi ? {wdata, 32'h0} : {32'h0, wdata};
      wr_mask   = half_mask & ~BUS_RO;

      nxt = base;
      if (wr_en) begin
         nxt = (base & ~wr_mask) | (data64 & wr_mask);
         if (!nxt[BIT_TRIG]) nxt[BIT_IRR] = 1'b0;
      end

      route_chg = wr_en & (((entry_q ^ nxt) & ~ROUTE_IGN) != '0);
      redo      = wr_en & nxt[BIT_TRIG] & pin_lvl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_q <= ENT_RST;
      end else begin
         entry_q <= nxt;
      end
   end
endmodule

// File: rtl/read_mux.sv
module read_mux
   import irr_pkg::*;
#(
   parameter int unsigned NPIN  = 32,
   parameter int unsigned PIN_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  acc_kind_t             kind,
   input  win_sel_e              sel,
   input  logic [PIN_W-1:0]      ent_num,
   input  logic [31:0]           idx_q,
   input  logic [31:0]           id_q,
   input  logic [NPIN*ENT_W-1:0] entries,
   output logic [31:0]           rdata_q
);
   localparam logic [31:0] VER_WORD = (32'(NPIN - 1) << 16) | VER_LOW;

   logic [ENT_W-1:0] ent_word;
   logic [31:0]      win_val;

   assign ent_word = entries[int'(ent_num)*ENT_W +: ENT_W];

   always_comb begin
      case (sel)
         SEL_ID:     win_val = id_q;
         SEL_VER:    win_val = VER_WORD;
         SEL_ARB:    win_val = id_q;
         SEL_ENT_LO: win_val = ent_word[31:0];
         SEL_ENT_HI: win_val = ent_word[63:32];
         default:    win_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (kind.idx_rd) begin
         rdata_q <= idx_q;
      end else if (kind.win_rd) begin
         rdata_q <= win_val;
      end else if (kind.bad_rd) begin
         rdata_q <= '0;
      end
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irr_pkg::*;
#(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned ADDR_W = 8,
   localparam int unsigned PIN_W = $clog2(NPIN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic                  acc_write,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [2:0]            acc_size,
   input  logic [31:0]           acc_wdata,
   output logic [31:0]           acc_rdata,
   input  logic [NPIN-1:0]       pin_level,
   input  logic [NPIN-1:0]       irr_set,
   input  logic [NPIN-1:0]       irr_clr,
   output logic [NPIN*ENT_W-1:0] entry_tbl,
   output logic                  route_chg,
   output logic                  redeliver,
   output logic [PIN_W-1:0]      evt_pin
);
   if (NPIN < 2 || NPIN > 120) begin : g_bad_npin
      $error("NPIN must lie in 2..120 so every entry index fits in 8 bits");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end

   acc_kind_t        kind;
   logic [31:0]      idx_q;
   win_sel_e         sel;
   logic [PIN_W-1:0] ent_num;
   logic [31:0]      id_q;
   logic [NPIN-1:0]  route_vec;
   logic [NPIN-1:0]  redo_vec;
   logic             ent_sel;

   win_decode #(.NPIN(NPIN), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .acc_wdata (acc_wdata),
      .kind      (kind),
      .idx_q     (idx_q),
      .sel       (sel),
      .ent_num   (ent_num)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_q <= '0;
      end else if (kind.win_wr && sel == SEL_ID) begin
         id_q <= acc_wdata & ID_FIELD;
      end
   end

   assign ent_sel = (sel == SEL_ENT_LO) || (sel == SEL_ENT_HI);

   for (genvar g = 0; g < NPIN; g++) begin : g_ent
      logic wr_here;
      assign wr_here = kind.win_wr && ent_sel && (ent_num == PIN_W'(g));

      route_entry u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_here),
         .wr_hi     (sel == SEL_ENT_HI),
         .wdata     (acc_wdata),
         .irr_set   (irr_set[g]),
         .irr_clr   (irr_clr[g]),
         .pin_lvl   (pin_level[g]),
         .entry_q   (entry_tbl[g*ENT_W +: ENT_W]),
         .route_chg (route_vec[g]),
         .redo      (redo_vec[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_chg <= 1'b0;
         redeliver <= 1'b0;
         evt_pin   <= '0;
      end else begin
         route_chg <= |route_vec;
         redeliver <= |redo_vec;
         evt_pin   <= ((|route_vec) || (|redo_vec)) ? ent_num : '0;
      end
   end

   read_mux #(.NPIN(NPIN), .PIN_W(PIN_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind),
      .sel     (sel),
      .ent_num (ent_num),
      .idx_q   (idx_q),
      .id_q    (id_q),
      .entries (entry_tbl),
      .rdata_q (acc_rdata)
   );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
   import irr_pkg::*;
#(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned PIN_W  = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  acc_valid,
   input logic                  acc_write,
   input logic [ADDR_W-1:0]     acc_addr,
   input logic [2:0]            acc_size,
   input logic [31:0]           acc_rdata,
   input logic [NPIN-1:0]       pin_level,
   input logic [NPIN-1:0]       irr_set,
   input logic [NPIN*ENT_W-1:0] entry_tbl,
   input logic                  route_chg,
   input logic                  redeliver,
   input logic [PIN_W-1:0]      evt_pin
);
   logic [NPIN-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= pin_level;
   end

   AST_ROUTE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      route_chg |-> $past(acc_valid && acc_write && acc_size == SIZE_WORD && acc_addr == ADDR_W'(OFS_WINDOW))); // R9

   AST_REDO_LEVEL_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      redeliver |-> (lvl_q[evt_pin] && entry_tbl[int'(evt_pin)*ENT_W + BIT_TRIG])); // R10

   AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid && !acc_write && acc_size != SIZE_WORD) |-> (acc_rdata == '0)); // R2

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_valid && !acc_write) |-> $stable(acc_rdata)); // R11

   for (genvar g = 0; g < NPIN; g++) begin : g_chk
      AST_IRR_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(entry_tbl[g*ENT_W + BIT_IRR]) |-> $past(irr_set[g])); // R7

      AST_EDGE_DROPS_IRR: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(entry_tbl[g*ENT_W + BIT_TRIG]) |-> !entry_tbl[g*ENT_W + BIT_IRR]); // R8
   end
endmodule

bind irq_route_regs irq_route_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_size  (acc_size),
   .acc_rdata (acc_rdata),
   .pin_level (pin_level),
   .irr_set   (irr_set),
   .entry_tbl (entry_tbl),
   .route_chg (route_chg),
   .redeliver (redeliver),
   .evt_pin   (evt_pin)
);

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NPIN   = 32;
   localparam int ADDR_W = 8;
   localparam int PIN_W  = 5;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                acc_valid, acc_write;
   logic [ADDR_W-1:0]   acc_addr;
   logic [2:0]          acc_size;
   logic [31:0]         acc_wdata;
   logic [31:0]         acc_rdata;
   logic [NPIN-1:0]     pin_level, irr_set, irr_clr;
   logic [NPIN*64-1:0]  entry_tbl;
   logic                route_chg, redeliver;
   logic [PIN_W-1:0]    evt_pin;

   int n_chk = 0;
   int n_fail = 0;

   logic [63:0] m_ent [NPIN];
   logic [31:0] m_idx, m_id, exp_rd;
   logic        exp_route, exp_redo;
   logic [PIN_W-1:0] exp_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_route_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .pin_level(pin_level), .irr_set(irr_set),
      .irr_clr(irr_clr), .entry_tbl(entry_tbl), .route_chg(route_chg),
      .redeliver(redeliver), .evt_pin(evt_pin)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] win_val(input logic [7:0] ix);
      if (ix == 8'h00 || ix == 8'h02) return m_id;
      if (ix == 8'h01) return ((NPIN - 1) << 16) | 32'h11;
      if (ix >= 8'h10 && int'(ix) < 16 + 2 * NPIN)
         return ix[0] ? m_ent[(ix - 8'h10) >> 1][63:32] : m_ent[(ix - 8'h10) >> 1][31:0];
      return 32'h0;
   endfunction

   // one bus cycle: drive at falling edge, update model, compare at next falling edge
   task automatic step(input string tag, input logic v, input logic w,
                       input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d,
                       input logic [NPIN-1:0] s, input logic [NPIN-1:0] c);
      logic [63:0] prev, diff;
      logic [7:0]  ix;
      int          n;
      acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
      irr_set = s; irr_clr = c;
      exp_route = 1'b0; exp_redo = 1'b0; exp_pin = '0;
      if (v && !w) begin
         if (sz != 3'd4)      exp_rd = 32'h0;
         else if (a == 8'h00) exp_rd = m_idx;
         else if (a == 8'h10) exp_rd = win_val(m_idx[7:0]);
         else                 exp_rd = 32'h0;
      end
      for (int k = 0; k < NPIN; k++) begin
         if (s[k]) m_ent[k][14] = 1'b1;
         if (c[k]) m_ent[k][14] = 1'b0;
      end
      if (v && w && sz == 3'd4) begin
         if (a == 8'h00) m_idx = d;
         else if (a == 8'h10) begin
            ix = m_idx[7:0];
            if (ix == 8'h00) m_id = d & 32'h0F00_0000;
            else if (ix >= 8'h10 && int'(ix) < 16 + 2 * NPIN) begin
               n = int'(ix - 8'h10) / 2;
               prev = m_ent[n];
               for (int b = 0; b < 32; b++) begin
                  int pos;
                  pos = (ix[0] ? 32 : 0) + b;
                  if (pos != 14 && pos != 12) m_ent[n][pos] = d[b];
               end
               if (!m_ent[n][15]) m_ent[n][14] = 1'b0;
               diff = prev ^ m_ent[n];
               diff[16] = 1'b0;
               diff[13] = 1'b0;
               exp_route = (diff != 64'h0);
               exp_redo  = m_ent[n][15] && pin_level[n];
               if (exp_route || exp_redo) exp_pin = PIN_W'(n);
            end
         end
      end
      @(negedge clk);
      chk(route_chg == exp_route, tag, "route_chg", 64'(route_chg), 64'(exp_route));
      chk(redeliver == exp_redo, tag, "redeliver", 64'(redeliver), 64'(exp_redo));
      chk(evt_pin == exp_pin, tag, "evt_pin", 64'(evt_pin), 64'(exp_pin));
      chk(acc_rdata == exp_rd, tag, "rdata", 64'(acc_rdata), 64'(exp_rd));
      begin
         int bad;
         bad = -1;
         for (int k = NPIN - 1; k >= 0; k--)
            if (entry_tbl[k*64 +: 64] !== m_ent[k]) bad = k;
         if (bad >= 0) chk(1'b0, tag, "entry", entry_tbl[bad*64 +: 64], m_ent[bad]);
         else          chk(1'b1, tag, "entry", 64'h0, 64'h0);
      end
   endtask

   task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
      step(tag, 1'b1, 1'b1, a, 3'd4, d, '0, '0);
   endtask
   task automatic rd(input string tag, input logic [7:0] a);
      step(tag, 1'b1, 1'b0, a, 3'd4, 32'h0, '0, '0);
   endtask
   task automatic idle(input string tag);
      step(tag, 1'b0, 1'b0, 8'h00, 3'd0, 32'h0, '0, '0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_size = '0;
      acc_wdata = '0; pin_level = '0; irr_set = '0; irr_clr = '0;
      for (int k = 0; k < NPIN; k++) m_ent[k] = 64'h0001_0000_0001_0000;
      m_idx = '0; m_id = '0; exp_rd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      idle("R1");
      rd("R1", 8'h00);
      // R3 index readback and low-byte selection; R4 version
      wr("R3", 8'h00, 32'hABCD_1201);
      rd("R3", 8'h00);
      rd("R4", 8'h10);
      // R5 identification mask, R4 arbitration mirror
      wr("R5", 8'h00, 32'h0);
      wr("R5", 8'h10, 32'hFFFF_FFFF);
      rd("R4", 8'h10);
      wr("R4", 8'h00, 32'h2);
      rd("R4", 8'h10);
      wr("R5", 8'h10, 32'h0300_0000);
      rd("R5", 8'h10);
      wr("R5", 8'h00, 32'h1);
      wr("R5", 8'h10, 32'h0);
      rd("R5", 8'h10);
      // R6 first and last entries, unmapped indices
      wr("R6", 8'h00, 32'h10);
      wr("R6", 8'h10, 32'h0000_0031);
      rd("R6", 8'h10);
      wr("R6", 8'h00, 32'h4F);
      wr("R6", 8'h10, 32'hAB00_0000);
      rd("R6", 8'h10);
      wr("R6", 8'h00, 32'h50);
      wr("R6", 8'h10, 32'hFFFF_FFFF);
      rd("R6", 8'h10);
      wr("R6", 8'h00, 32'h03);
      rd("R6", 8'h10);
      wr("R6", 8'h00, 32'h0F);
      rd("R6", 8'h10);
      // R7 read-only bits, delivery-side set and clear
      wr("R7", 8'h00, 32'h1A);
      wr("R7", 8'h10, 32'hFFFF_FFFF);
      rd("R7", 8'h10);
      step("R7", 1'b0, 1'b0, 8'h0, 3'd0, 32'h0, 32'h0000_0020, '0);
      rd("R7", 8'h10);
      wr("R7", 8'h10, 32'h0000_8040);
      rd("R7", 8'h10);
      // R8 switching to edge clears remote-IRR
      wr("R8", 8'h10, 32'h0000_0040);
      rd("R8", 8'h10);
      step("R7", 1'b0, 1'b0, 8'h0, 3'd0, 32'h0, 32'h0000_0020, '0);
      step("R7", 1'b0, 1'b0, 8'h0, 3'd0, 32'h0, '0, 32'h0000_0020);
      // R9 routing change detection on entry 9
      wr("R9", 8'h00, 32'h22);
      wr("R9", 8'h10, 32'h0001_2000);
      wr("R9", 8'h10, 32'h0000_0000);
      wr("R9", 8'h10, 32'h0000_0077);
      wr("R9", 8'h10, 32'h0000_0077);
      // R10 re-delivery on entry 7
      pin_level = 32'h0000_0080;
      wr("R10", 8'h00, 32'h1E);
      wr("R10", 8'h10, 32'h0000_8055);
      wr("R10", 8'h10, 32'h0000_8055);
      wr("R10", 8'h10, 32'h0000_0055);
      pin_level = '0;
      wr("R10", 8'h10, 32'h0000_8055);
      // R2 rejected sizes and offsets
      step("R2", 1'b1, 1'b1, 8'h00, 3'd2, 32'h77, '0, '0);
      rd("R2", 8'h00);
      step("R2", 1'b1, 1'b1, 8'h04, 3'd4, 32'h5, '0, '0);
      rd("R2", 8'h04);
      rd("R2", 8'h00);
      step("R2", 1'b1, 1'b0, 8'h10, 3'd1, 32'h0, '0, '0);
      step("R2", 1'b1, 1'b1, 8'h10, 3'd8, 32'hFFFF_FFFF, '0, '0);
      // R11 read data holds without a read
      rd("R11", 8'h10);
      idle("R11");
      wr("R11", 8'h00, 32'h01);
      idle("R11");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule